// File: doc/BRIEF.md
# Write-only two-wire configuration receiver

This block is a receive-only slave on a two-wire serial bus. It runs in the system clock domain and oversamples the bus clock and data lines. It loads a file of seven 8-bit configuration registers that drive the rest of the chip. A bus master writes one transaction made of ten bytes:

- a device address byte;
- a command byte and a count byte, both of which the block accepts and throws away;
- seven data bytes, which land in registers 0 to 6 in that order.

The block pulls the data line low to acknowledge each byte it accepts. It has no read path.

Both bus lines pass through a two-flop synchronizer and then a three-sample majority filter. Start, stop and bit edges are decided on the filtered lines. A start seen in the middle of a transfer abandons that transfer and begins address matching again. A stop closes the transfer. Every data byte is written into its register at the moment its eighth bit completes, so bytes already taken stay written whatever happens afterwards.

Top module: `cfg2w_rx`

## Requirements
- R1: After reset the registers hold these values: register 0 = 0x00, register 1 = 0x0F, register 2 = 0x3F, register 3 = 0xFF, register 4 = 0x3F, register 5 = 0x01, register 6 = 0x00. Register k appears on `cfgRegs[8k+7:8k]`. `sdaPullLow` is 0.
- R2: The first byte after a start must be exactly 0xD2. If it is not, the block acknowledges nothing until the next start and changes no register.
- R3: After a matching address, the second and third bytes are acknowledged and change no register. The following data bytes go to register 0, then 1, and so on up to 6. Each byte is taken MSB first, sampled while SCL is high.
- R4: For every byte the block accepts, `sdaPullLow` is 1 throughout the high phase of the ninth SCL clock. It is 0 during the eight data clocks.
- R5: Data bytes after the seventh are acknowledged and leave all registers unchanged.
- R6: A start inside a transfer restarts address matching, and data bytes written before it stay in their registers. After a stop, bytes sent without a new start are neither acknowledged nor stored.
- R7: A pulse lasting one system clock on SCL or on SDA has no effect on the received data.
- R8: A byte cut short by a stop before its eighth bit is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad, including this block's own pull-down |
| sdaPullLow | output | 1 | 1 = drive the data line low (open-drain acknowledge) |
| cfgRegs | output | 56 | Configuration register file; register k at bits [8k+7:8k] |

## Verification
The assertions assume that every bus phase lasts well beyond the synchronizer and filter latency of about six clocks. They also assume that SDA changes only while SCL is low, apart from start and stop, and that the master lets SDA go during the acknowledge clock. Under those conditions the acknowledge can only change while the filtered clock is low. The bench holds each bus phase for ten system clocks and drives SDA as an open-drain line combined with `sdaPullLow`. Its deliberate glitches last a single clock, so they stay inside what the filter is meant to reject.

// File: rtl/cfg2w_pkg.sv
package cfg2w_pkg;
  typedef struct packed {
    logic shiftBit;
    logic clrPtr;
    logic commitByte;
  } dpStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_ACK, ST_IGNORE} rxState_t;
endpackage

// File: rtl/cfg2w_filter.sv
module cfg2w_filter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] rawIn,
  output logic [W-1:0] cleanOut
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [1:0] syncQ;
    logic [2:0] hist;
    logic       outQ;
    logic       vote;

    assign vote = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 2'b11;
        hist  <= 3'b111;
        outQ  <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        hist  <= {hist[1:0], syncQ[1]};
        outQ  <= vote;
      end
    end

    assign cleanOut[g] = outQ;
  end
endmodule

// File: rtl/cfg2w_datapath.sv
module cfg2w_datapath
  import cfg2w_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 56'h00_01_3F_FF_3F_0F_00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic                  sdaBit,
  output logic [7:0]            rxByte,
  output logic [NUM_REGS*8-1:0] regsOut
);
  localparam int PTR_W = $clog2(NUM_REGS + 1);

  logic [7:0]       shiftQ;
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= 8'h00;
    else if (strb.shiftBit) shiftQ <= {shiftQ[6:0], sdaBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (strb.clrPtr) ptr <= '0;
    else if (strb.commitByte && ptr < PTR_W'(NUM_REGS)) ptr <= ptr + PTR_W'(1);
  end

  assign rxByte = shiftQ;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= REG_DEFAULTS[g*8 +: 8];
      else if (strb.commitByte && ptr == PTR_W'(g)) q <= shiftQ;
    end
    assign regsOut[g*8 +: 8] = q;
  end

  // R5: once the file is full, a commit strobe writes nothing
  p_full_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitByte && ptr == PTR_W'(NUM_REGS)) |=> $stable(regsOut));

  // R3: registers only move on a commit strobe from the control
  p_write_needs_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitByte |=> $stable(regsOut));
endmodule

// File: rtl/cfg2w_ctrl.sv
module cfg2w_ctrl
  import cfg2w_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hD2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic [7:0] rxByte,
  output dpStrobe_t strb,
  output logic      sdaPullLow
);
  rxState_t   state;
  logic [3:0] bitCnt;
  logic [1:0] hdrCnt;
  logic       ackQ;
  logic       sclPrev;
  logic       sdaPrev;

  logic sclRise, sclFall, startDet, stopDet, byteDone, addrOk;

  assign sclRise  = sclF & ~sclPrev;
  assign sclFall  = ~sclF & sclPrev;
  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;
  assign byteDone = (state == ST_BITS) && (bitCnt == 4'd8) && sclFall;
  assign addrOk   = (hdrCnt != 2'd0) || (rxByte == DEV_ADDR);

  always_comb begin
    strb.shiftBit   = (state == ST_BITS) && sclRise && (bitCnt < 4'd8);
    strb.clrPtr     = startDet;
    strb.commitByte = byteDone && (hdrCnt == 2'd3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= 4'd0;
      hdrCnt <= 2'd0;
      ackQ   <= 1'b0;
    end else if (startDet) begin
      state  <= ST_BITS;
      bitCnt <= 4'd0;
      hdrCnt <= 2'd0;
      ackQ   <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      ackQ  <= 1'b0;
    end else begin
      case (state)
        ST_BITS: begin
          if (strb.shiftBit) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            if (addrOk) begin
              ackQ   <= 1'b1;
              state  <= ST_ACK;
              bitCnt <= 4'd0;
              if (hdrCnt != 2'd3) hdrCnt <= hdrCnt + 2'd1;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackQ  <= 1'b0;
            state <= ST_BITS;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaPullLow = ackQ;

  // R4: the acknowledge pull only starts or ends while the clock line is low
  p_ack_edges_scl_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ackQ != $past(ackQ)) |-> !sclF);

  // R2: after an address mismatch the block stays silent and writes nothing
  p_ignore_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> (!ackQ && !strb.commitByte));

  // R4: an acknowledge follows eight received bits
  p_ack_after_eight_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackQ) |-> ($past(bitCnt) == 4'd8));
endmodule

// File: rtl/cfg2w_rx.sv
module cfg2w_rx
  import cfg2w_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter logic [7:0] DEV_ADDR = 8'hD2,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 56'h00_01_3F_FF_3F_0F_00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPullLow,
  output logic [NUM_REGS*8-1:0] cfgRegs
);
  logic [1:0] cleanLines;
  logic       sclF;
  logic       sdaF;
  logic [7:0] rxByte;
  dpStrobe_t  strb;

  cfg2w_filter #(.W(2)) filt_i (
    .clk(clk), .rstN(rstN), .rawIn({sclIn, sdaIn}), .cleanOut(cleanLines)
  );

  assign sclF = cleanLines[1];
  assign sdaF = cleanLines[0];

  cfg2w_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .rxByte(rxByte),
    .strb(strb), .sdaPullLow(sdaPullLow)
  );

  cfg2w_datapath #(.NUM_REGS(NUM_REGS), .REG_DEFAULTS(REG_DEFAULTS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaF),
    .rxByte(rxByte), .regsOut(cfgRegs)
  );
endmodule

// File: tb/cfg2w_rx_tb.sv
module cfg2w_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow;
  logic [55:0] cfgRegs;
  logic sdaBus;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] expRegs [7];
  logic [7:0] txData [16];

  assign sdaBus = sdaM & ~sdaPullLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg2w_rx dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .cfgRegs(cfgRegs)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkRegs(input string req);
    for (int k = 0; k < 7; k++) chk(req, 64'(cfgRegs[k*8 +: 8]), 64'(expRegs[k]));
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(PH);
    sclM = 1'b1; waitClk(PH);
    sdaM = 1'b0; waitClk(PH);
    sclM = 1'b0; waitClk(PH);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(PH);
    sclM = 1'b1; waitClk(PH);
    sdaM = 1'b1; waitClk(PH);
  endtask

  // sends one byte MSB first, returns the acknowledge seen in the ninth clock
  task automatic sendBits(input logic [7:0] b, input int nBits, input bit glitch,
                          output bit gotAck);
    bit pullInBits = 1'b0;
    for (int i = 7; i > 7 - nBits; i--) begin
      sdaM = b[i];
      waitClk(PH/2);
      if (glitch) begin sclM = 1'b1; waitClk(1); sclM = 1'b0; end
      waitClk(PH/2);
      sclM = 1'b1;
      waitClk(PH/2);
      if (sdaPullLow) pullInBits = 1'b1;
      if (glitch && b[i]) begin sdaM = 1'b0; waitClk(1); sdaM = 1'b1; end
      waitClk(PH/2);
      sclM = 1'b0;
      waitClk(PH);
    end
    gotAck = 1'b0;
    if (nBits == 8) begin
      sdaM = 1'b1; waitClk(PH);
      sclM = 1'b1; waitClk(PH/2);
      gotAck = sdaPullLow;
      waitClk(PH/2);
      sclM = 1'b0; waitClk(PH);
    end
    chk("R4 no pull during data clocks", 64'(pullInBits), 64'(0));
  endtask

  task automatic sendByte(input logic [7:0] b, input string req, input bit expAck);
    bit a;
    sendBits(b, 8, 1'b0, a);
    chk(req, 64'(a), 64'(expAck));
  endtask

  task automatic writeTxn(input logic [7:0] addr, input int nData, input string req);
    bit ok;
    ok = (addr == 8'hD2);
    busStart();
    sendByte(addr, {req, " addr ack"}, ok);
    sendByte(8'h5C, {req, " command ack R3"}, ok);
    sendByte(8'(nData), {req, " count ack R3"}, ok);
    for (int k = 0; k < nData; k++) sendByte(txData[k], {req, " data ack"}, ok);
    busStop();
    waitClk(PH);
    if (ok) for (int k = 0; k < nData && k < 7; k++) expRegs[k] = txData[k];
    chkRegs({req, " regs"});
  endtask

  task automatic t_reset();
    chk("R1 pull idle", 64'(sdaPullLow), 64'(0));
    chkRegs("R1 defaults");
  endtask

  task automatic t_full_write();
    txData[0] = 8'h12; txData[1] = 8'h34; txData[2] = 8'hC1; txData[3] = 8'h07;
    txData[4] = 8'hE8; txData[5] = 8'h9B; txData[6] = 8'h60;
    writeTxn(8'hD2, 7, "R3");
  endtask

  task automatic t_bad_addr();
    txData[0] = 8'hAA; txData[1] = 8'h55; txData[2] = 8'h0F;
    writeTxn(8'hD4, 3, "R2 mismatch D4");
    writeTxn(8'hD3, 3, "R2 mismatch read bit");
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 9; k++) txData[k] = 8'(8'h21 + 8'(k) * 8'h11);
    writeTxn(8'hD2, 9, "R5");
  endtask

  task automatic t_restart();
    bit a;
    busStart();
    sendByte(8'hD2, "R6 addr", 1'b1);
    sendByte(8'h00, "R6 cmd", 1'b1);
    sendByte(8'h07, "R6 cnt", 1'b1);
    sendByte(8'h3A, "R6 d0", 1'b1);
    sendByte(8'h4B, "R6 d1", 1'b1);
    expRegs[0] = 8'h3A; expRegs[1] = 8'h4B;
    busStart();
    sendByte(8'hD2, "R6 restart addr", 1'b1);
    sendByte(8'h00, "R6 restart cmd", 1'b1);
    sendByte(8'h07, "R6 restart cnt", 1'b1);
    sendByte(8'hC6, "R6 restart d0", 1'b1);
    expRegs[0] = 8'hC6;
    busStop();
    waitClk(PH);
    chkRegs("R6 after restart");
    sendBits(8'hD2, 8, 1'b0, a);
    chk("R6 no ack after stop", 64'(a), 64'(0));
    sendBits(8'h99, 8, 1'b0, a);
    chk("R6 no ack after stop data", 64'(a), 64'(0));
    waitClk(PH);
    chkRegs("R6 no write after stop");
  endtask

  task automatic t_partial();
    bit a;
    busStart();
    sendByte(8'hD2, "R8 addr", 1'b1);
    sendByte(8'h00, "R8 cmd", 1'b1);
    sendByte(8'h07, "R8 cnt", 1'b1);
    sendByte(8'h71, "R8 d0", 1'b1);
    expRegs[0] = 8'h71;
    sendBits(8'hFF, 4, 1'b0, a);
    busStop();
    waitClk(PH);
    chkRegs("R8 partial byte");
  endtask

  task automatic t_glitch();
    bit a;
    busStart();
    sendByte(8'hD2, "R7 addr", 1'b1);
    sendByte(8'h00, "R7 cmd", 1'b1);
    sendByte(8'h07, "R7 cnt", 1'b1);
    sendBits(8'hB5, 8, 1'b1, a);
    chk("R7 glitched byte ack", 64'(a), 64'(1));
    sendBits(8'h6D, 8, 1'b1, a);
    chk("R7 glitched byte ack", 64'(a), 64'(1));
    expRegs[0] = 8'hB5; expRegs[1] = 8'h6D;
    busStop();
    waitClk(PH);
    chkRegs("R7 glitch rejected");
  endtask

  initial begin
    expRegs[0] = 8'h00; expRegs[1] = 8'h0F; expRegs[2] = 8'h3F; expRegs[3] = 8'hFF;
    expRegs[4] = 8'h3F; expRegs[5] = 8'h01; expRegs[6] = 8'h00;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    t_reset();
    t_full_write();
    t_bad_addr();
    t_overflow();
    t_restart();
    t_partial();
    t_glitch();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule